// File: doc/BRIEF.md
# Machine-Level Control Register and Trap Unit

This block keeps the machine-level control registers of a small processor core and performs the atomic read-modify-write operations that software uses on them. A core presents one register access per cycle: an operation code, a 12-bit register address and either a source register value or a 5-bit immediate. The unit returns the value the register held before the access, so it can go to the destination register. It commits the write, or withholds it, at the next clock edge.

The same unit records trap state. When the core raises a trap, the unit saves the cause code, the faulting program counter and an extra trap value. It also saves the interrupt-enable bit and clears it, and it provides the handler entry address taken from the trap vector register. On a trap return it restores the interrupt enable and offers the saved program counter as the resume address. An access to an address the unit does not implement, or a write to the read-only address range, is flagged as illegal and leaves every register unchanged.

Top module: `csr_trap_unit`

## Requirements
- R1: Operation code bits [1:0] = 01 (write) return the old value on `rd_data` in the same cycle, and after the next edge the register holds the operand.
- R2: Bits [1:0] = 10 (set) OR the operand into the register, and bits [1:0] = 11 (clear) AND the register with the inverted operand. Both return the old value. Bits [1:0] = 00 is illegal.
- R3: Operation code bit 2 = 1 selects the immediate form. The operand is then `acc_zimm` zero-extended to XLEN in place of `acc_src`.
- R4: A set or clear whose operand is zero writes nothing. It is therefore legal even on a read-only address, and it still returns the old value.
- R5: A write-form access with `acc_rd_zero` = 1 still writes the register but returns 0 on `rd_data`.
- R6: On `trap_valid` the cause register takes `trap_cause` (an environment call uses cause 8), the exception PC takes `trap_pc` with bit 0 cleared, and the trap value register takes `trap_tval`.
- R7: `trap_target` is the trap vector register with its two low bits cleared. `ret_target` is the exception PC register, and bit 0 of that register always reads 0, even after a software write.
- R8: The status register (0x300) reads bit 3 = interrupt enable (IE), bit 7 = previous enable (PIE) and bits [12:11] = 11. All other bits read 0 and only bits 3 and 7 are writable. A trap copies IE into PIE and clears IE. A return with no trap copies PIE into IE and sets PIE.
- R9: `illegal` is asserted for an unimplemented address, for op bits 00, and for a write to an address whose bits [11:10] are 11. When `illegal` is set, `rd_data` is 0 and no register changes.
- R10: A trap in the same cycle as an access or a return wins: the register write and the return are dropped. A return also drops a register write in its cycle.
- R11: Reset leaves IE and PIE at 0, the trap vector at TVEC_RESET (default 0x100), and every other writable register at 0.
- R12: The implemented addresses are status 0x300, vector 0x305, scratch 0x340, exception PC 0x341, cause 0x342, trap value 0x343 and a read-only core ID at 0xF14 that returns HART_ID (default 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_valid | input | 1 | Register access request this cycle |
| acc_op | input | 3 | Bit 2 selects immediate; bits [1:0] select write/set/clear |
| acc_addr | input | 12 | Register address |
| acc_src | input | XLEN | Source register operand |
| acc_zimm | input | 5 | Immediate operand |
| acc_rd_zero | input | 1 | Destination register is the zero register |
| trap_valid | input | 1 | Trap entry this cycle |
| trap_cause | input | XLEN | Cause code |
| trap_pc | input | XLEN | Faulting program counter |
| trap_tval | input | XLEN | Extra trap information |
| ret_valid | input | 1 | Trap return this cycle |
| rd_data | output | XLEN | Old register value for the destination |
| illegal | output | 1 | Access is illegal |
| trap_target | output | XLEN | Handler entry address |
| ret_target | output | XLEN | Resume address |

## Verification
A register access and a trap can land in the same cycle, and so can a return and a trap. Random stimulus raises traps and returns independently of accesses, so the three inputs often coincide. Directed cases also aim a trap at a write to the scratch register and then read that register back. The bench's reference model applies the trap first, drops the write and the return, and judges the result through the following reads of the scratch, status and exception PC registers.

// File: rtl/csr_trap_pkg.sv
package csr_trap_pkg;
  typedef enum logic [1:0] {K_NONE = 2'b00, K_WRITE = 2'b01, K_SET = 2'b10, K_CLEAR = 2'b11} rmw_kind_e;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_STATUS, SEL_TVEC, SEL_SCRATCH, SEL_EPC, SEL_CAUSE, SEL_TVAL, SEL_HARTID
  } csr_sel_e;

  localparam logic [11:0] A_STATUS  = 12'h300;
  localparam logic [11:0] A_TVEC    = 12'h305;
  localparam logic [11:0] A_SCRATCH = 12'h340;
  localparam logic [11:0] A_EPC     = 12'h341;
  localparam logic [11:0] A_CAUSE   = 12'h342;
  localparam logic [11:0] A_TVAL    = 12'h343;
  localparam logic [11:0] A_HARTID  = 12'hF14;

  localparam int IE_BIT  = 3;
  localparam int PIE_BIT = 7;
endpackage

// File: rtl/csr_decode.sv
module csr_decode
  import csr_trap_pkg::*;
(
  input  logic [11:0] addr,
  input  rmw_kind_e   kind,
  input  logic        wr_intent,
  output csr_sel_e    sel,
  output logic        illegal
);
  logic read_only;

  always_comb begin
    case (addr)
      A_STATUS:  sel = SEL_STATUS;
      A_TVEC:    sel = SEL_TVEC;
      A_SCRATCH: sel = SEL_SCRATCH;
      A_EPC:     sel = SEL_EPC;
      A_CAUSE:   sel = SEL_CAUSE;
      A_TVAL:    sel = SEL_TVAL;
      A_HARTID:  sel = SEL_HARTID;
      default:   sel = SEL_NONE;
    endcase
  end

  assign read_only = (addr[11:10] == 2'b11);
  assign illegal   = (sel == SEL_NONE) || (kind == K_NONE) || (read_only && wr_intent);
endmodule

// File: rtl/csr_rmw.sv
module csr_rmw
  import csr_trap_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  rmw_kind_e         kind,
  input  logic              use_imm,
  input  logic [XLEN-1:0]   src,
  input  logic [4:0]        zimm,
  input  logic [XLEN-1:0]   old_val,
  output logic [XLEN-1:0]   new_val,
  output logic              wr_intent
);
  logic [XLEN-1:0] operand;

  function automatic logic [XLEN-1:0] rmw_apply(rmw_kind_e k, logic [XLEN-1:0] cur,
                                                logic [XLEN-1:0] opnd);
    case (k)
      K_WRITE: return opnd;
      K_SET:   return cur | opnd;
      K_CLEAR: return cur & ~opnd;
      default: return cur;
    endcase
  endfunction

  assign operand   = use_imm ? XLEN'(zimm) : src;
  assign new_val   = rmw_apply(kind, old_val, operand);
  assign wr_intent = (kind == K_WRITE) || (operand != '0);
endmodule

// File: rtl/csr_regs.sv
module csr_regs
  import csr_trap_pkg::*;
#(
  parameter int              XLEN       = 32,
  parameter logic [XLEN-1:0] TVEC_RESET = XLEN'(32'h100),
  parameter logic [XLEN-1:0] HART_ID    = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  csr_sel_e        sel,
  input  logic            we,
  input  logic [XLEN-1:0] wdata,
  input  logic            trap_take,
  input  logic            ret_take,
  input  logic [XLEN-1:0] trap_cause,
  input  logic [XLEN-1:0] trap_pc,
  input  logic [XLEN-1:0] trap_tval,
  output logic [XLEN-1:0] rd_val,
  output logic [XLEN-1:0] tvec_q,
  output logic [XLEN-1:0] epc_q,
  output logic [XLEN-1:0] scratch_q,
  output logic [XLEN-1:0] cause_q,
  output logic            ie_q,
  output logic            pie_q
);
  localparam logic [XLEN-1:0] EVEN_MASK = ~XLEN'(1);

  logic [XLEN-1:0] tval_q;

  function automatic logic [XLEN-1:0] status_image(logic ie, logic pie);
    logic [XLEN-1:0] v;
    v = '0;
    v[IE_BIT]  = ie;
    v[PIE_BIT] = pie;
    v[12:11]   = 2'b11;
    return v;
  endfunction

  always_comb begin
    case (sel)
      SEL_STATUS:  rd_val = status_image(ie_q, pie_q);
      SEL_TVEC:    rd_val = tvec_q;
      SEL_SCRATCH: rd_val = scratch_q;
      SEL_EPC:     rd_val = epc_q;
      SEL_CAUSE:   rd_val = cause_q;
      SEL_TVAL:    rd_val = tval_q;
      SEL_HARTID:  rd_val = HART_ID;
      default:     rd_val = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie_q      <= 1'b0;
      pie_q     <= 1'b0;
      tvec_q    <= TVEC_RESET;
      scratch_q <= '0;
      epc_q     <= '0;
      cause_q   <= '0;
      tval_q    <= '0;
    end else if (trap_take) begin
      epc_q   <= trap_pc & EVEN_MASK;
      cause_q <= trap_cause;
      tval_q  <= trap_tval;
      pie_q   <= ie_q;
      ie_q    <= 1'b0;
    end else if (ret_take) begin
      ie_q  <= pie_q;
      pie_q <= 1'b1;
    end else if (we) begin
      case (sel)
        SEL_STATUS: begin
          ie_q  <= wdata[IE_BIT];
          pie_q <= wdata[PIE_BIT];
        end
        SEL_TVEC:    tvec_q    <= wdata;
        SEL_SCRATCH: scratch_q <= wdata;
        SEL_EPC:     epc_q     <= wdata & EVEN_MASK;
        SEL_CAUSE:   cause_q   <= wdata;
        SEL_TVAL:    tval_q    <= wdata;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/csr_trap_unit.sv
module csr_trap_unit
  import csr_trap_pkg::*;
#(
  parameter int              XLEN       = 32,
  parameter logic [XLEN-1:0] TVEC_RESET = XLEN'(32'h100),
  parameter logic [XLEN-1:0] HART_ID    = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            acc_valid,
  input  logic [2:0]      acc_op,
  input  logic [11:0]     acc_addr,
  input  logic [XLEN-1:0] acc_src,
  input  logic [4:0]      acc_zimm,
  input  logic            acc_rd_zero,
  input  logic            trap_valid,
  input  logic [XLEN-1:0] trap_cause,
  input  logic [XLEN-1:0] trap_pc,
  input  logic [XLEN-1:0] trap_tval,
  input  logic            ret_valid,
  output logic [XLEN-1:0] rd_data,
  output logic            illegal,
  output logic [XLEN-1:0] trap_target,
  output logic [XLEN-1:0] ret_target
);
  rmw_kind_e       kind;
  csr_sel_e        sel;
  logic            wr_intent;
  logic            dec_illegal;
  logic            csr_we;
  logic            ret_take;
  logic [XLEN-1:0] old_val, new_val;
  logic [XLEN-1:0] tvec_q, epc_q, scratch_q, cause_q;
  logic            ie_q, pie_q;

  assign kind = rmw_kind_e'(acc_op[1:0]);

  csr_rmw #(.XLEN(XLEN)) i_rmw (
    .kind(kind), .use_imm(acc_op[2]), .src(acc_src), .zimm(acc_zimm),
    .old_val(old_val), .new_val(new_val), .wr_intent(wr_intent)
  );

  csr_decode i_dec (
    .addr(acc_addr), .kind(kind), .wr_intent(wr_intent), .sel(sel), .illegal(dec_illegal)
  );

  assign illegal  = acc_valid && dec_illegal;
  assign ret_take = ret_valid && !trap_valid;
  assign csr_we   = acc_valid && !dec_illegal && wr_intent && !trap_valid && !ret_valid;

  csr_regs #(.XLEN(XLEN), .TVEC_RESET(TVEC_RESET), .HART_ID(HART_ID)) i_regs (
    .clk(clk), .rst_n(rst_n), .sel(sel), .we(csr_we), .wdata(new_val),
    .trap_take(trap_valid), .ret_take(ret_take),
    .trap_cause(trap_cause), .trap_pc(trap_pc), .trap_tval(trap_tval),
    .rd_val(old_val), .tvec_q(tvec_q), .epc_q(epc_q), .scratch_q(scratch_q),
    .cause_q(cause_q), .ie_q(ie_q), .pie_q(pie_q)
  );

  assign rd_data     = (acc_valid && !dec_illegal && !(kind == K_WRITE && acc_rd_zero)) ? old_val : '0;
  assign trap_target = {tvec_q[XLEN-1:2], 2'b00};
  assign ret_target  = epc_q;
endmodule

// File: rtl/csr_trap_checker.sv
module csr_trap_checker #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            acc_valid,
  input logic            illegal,
  input logic            trap_valid,
  input logic            ret_valid,
  input logic            csr_we,
  input logic [XLEN-1:0] trap_pc,
  input logic [XLEN-1:0] trap_cause,
  input logic [XLEN-1:0] trap_target,
  input logic [XLEN-1:0] ret_target,
  input logic [XLEN-1:0] epc_q,
  input logic [XLEN-1:0] cause_q,
  input logic [XLEN-1:0] scratch_q,
  input logic [XLEN-1:0] tvec_q,
  input logic            ie_q,
  input logic            pie_q
);
  p_trap_capture_r6: assert property (@(posedge clk) disable iff (!rst_n)
    trap_valid |=> (epc_q == ($past(trap_pc) & ~XLEN'(1))) && (cause_q == $past(trap_cause)));

  p_target_align_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_target[1:0] == 2'b00) && (ret_target[0] == 1'b0));

  p_trap_enable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    trap_valid |=> !ie_q && (pie_q == $past(ie_q)));

  p_return_enable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid && !trap_valid) |=> pie_q && (ie_q == $past(pie_q)));

  p_illegal_nowrite_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && illegal) |-> !csr_we);

  p_illegal_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && illegal && !trap_valid && !ret_valid) |=> $stable(scratch_q) && $stable(tvec_q));

  p_trap_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_valid && acc_valid) |=> $stable(scratch_q) && $stable(tvec_q));
endmodule

bind csr_trap_unit csr_trap_checker #(.XLEN(XLEN)) i_chk (
  .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .illegal(illegal),
  .trap_valid(trap_valid), .ret_valid(ret_valid), .csr_we(csr_we),
  .trap_pc(trap_pc), .trap_cause(trap_cause), .trap_target(trap_target),
  .ret_target(ret_target), .epc_q(epc_q), .cause_q(cause_q), .scratch_q(scratch_q),
  .tvec_q(tvec_q), .ie_q(ie_q), .pie_q(pie_q)
);

// File: tb/test_csr_trap_unit.sv
module test_csr_trap_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0;
  logic [2:0]  acc_op = '0;
  logic [11:0] acc_addr = '0;
  logic [31:0] acc_src = '0;
  logic [4:0]  acc_zimm = '0;
  logic        acc_rd_zero = 1'b0;
  logic        trap_valid = 1'b0;
  logic [31:0] trap_cause = '0, trap_pc = '0, trap_tval = '0;
  logic        ret_valid = 1'b0;
  logic [31:0] rd_data, trap_target, ret_target;
  logic        illegal;

  int n_checks = 0;
  int n_err = 0;

  // reference model state
  logic        m_ie = 0, m_pie = 0;
  logic [31:0] m_tvec = 32'h100, m_scratch = 0, m_epc = 0, m_cause = 0, m_tval = 0;

  always #2 clk = ~clk;

  csr_trap_unit i_csr_trap_unit (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_op(acc_op), .acc_addr(acc_addr),
    .acc_src(acc_src), .acc_zimm(acc_zimm), .acc_rd_zero(acc_rd_zero),
    .trap_valid(trap_valid), .trap_cause(trap_cause), .trap_pc(trap_pc), .trap_tval(trap_tval),
    .ret_valid(ret_valid), .rd_data(rd_data), .illegal(illegal),
    .trap_target(trap_target), .ret_target(ret_target)
  );

  function automatic bit m_impl(logic [11:0] a);
    return a == 12'h300 || a == 12'h305 || a == 12'h340 || a == 12'h341 ||
           a == 12'h342 || a == 12'h343 || a == 12'hF14;
  endfunction

  function automatic logic [31:0] m_read(logic [11:0] a);
    case (a)
      12'h300: return (32'(m_ie) << 3) | (32'(m_pie) << 7) | 32'h1800;
      12'h305: return m_tvec;
      12'h340: return m_scratch;
      12'h341: return m_epc;
      12'h342: return m_cause;
      12'h343: return m_tval;
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // one cycle: drive at negedge, compare combinational outputs, then update model at the edge
  task automatic cyc(bit av, logic [2:0] op, logic [11:0] addr, logic [31:0] src, logic [4:0] zimm,
                     bit rdz, bit tv, logic [31:0] cause, logic [31:0] pc, logic [31:0] tval,
                     bit rv, string req);
    logic [31:0] opnd, old, exp_rd, nv;
    bit wr, ill;
    @(negedge clk);
    acc_valid = av; acc_op = op; acc_addr = addr; acc_src = src; acc_zimm = zimm;
    acc_rd_zero = rdz; trap_valid = tv; trap_cause = cause; trap_pc = pc; trap_tval = tval;
    ret_valid = rv;
    #1;
    opnd   = op[2] ? {27'd0, zimm} : src;
    wr     = (op[1:0] == 2'b01) || (opnd != 0);
    ill    = av && (!m_impl(addr) || op[1:0] == 2'b00 || (addr[11:10] == 2'b11 && wr));
    old    = m_read(addr);
    exp_rd = (av && !ill && !(op[1:0] == 2'b01 && rdz)) ? old : 32'h0;
    chk(rd_data == exp_rd, req, rd_data, exp_rd);
    chk(illegal == ill, req, 32'(illegal), 32'(ill));
    chk(trap_target == {m_tvec[31:2], 2'b00}, "R7", trap_target, {m_tvec[31:2], 2'b00});
    chk(ret_target == m_epc, "R7", ret_target, m_epc);
    @(posedge clk);
    if (tv) begin
      m_epc = pc & ~32'h1; m_cause = cause; m_tval = tval; m_pie = m_ie; m_ie = 0;
    end else if (rv) begin
      m_ie = m_pie; m_pie = 1;
    end else if (av && !ill && wr) begin
      case (op[1:0])
        2'b01:   nv = opnd;
        2'b10:   nv = old | opnd;
        default: nv = old & ~opnd;
      endcase
      case (addr)
        12'h300: begin m_ie = nv[3]; m_pie = nv[7]; end
        12'h305: m_tvec = nv;
        12'h340: m_scratch = nv;
        12'h341: m_epc = nv & ~32'h1;
        12'h342: m_cause = nv;
        12'h343: m_tval = nv;
        default: ;
      endcase
    end
  endtask

  task automatic rd(logic [11:0] a, string req);
    cyc(1, 3'b010, a, 32'h0, 5'd0, 0, 0, 0, 0, 0, 0, req);
  endtask

  task automatic expect_val(logic [11:0] a, logic [31:0] v, string req);
    @(negedge clk);
    acc_valid = 1; acc_op = 3'b010; acc_addr = a; acc_src = 0; acc_rd_zero = 0;
    trap_valid = 0; ret_valid = 0;
    #1;
    chk(rd_data == v, req, rd_data, v);
  endtask

  initial begin
    #(4 * 190000);
    n_checks++; n_err++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R11 reset state
    expect_val(12'h300, 32'h1800, "R11");
    expect_val(12'h305, 32'h100, "R11");
    expect_val(12'h340, 32'h0, "R11");
    // R12 core id read-only, zero-operand set is legal
    cyc(1, 3'b010, 12'hF14, 0, 0, 0, 0, 0, 0, 0, 0, "R12");
    cyc(1, 3'b001, 12'hF14, 32'h5, 0, 0, 0, 0, 0, 0, 0, "R9");
    // R1 write returns old
    cyc(1, 3'b001, 12'h340, 32'hDEADBEEF, 0, 0, 0, 0, 0, 0, 0, "R1");
    expect_val(12'h340, 32'hDEADBEEF, "R1");
    // R2 set and clear
    cyc(1, 3'b010, 12'h343, 32'h0000_00F0, 0, 0, 0, 0, 0, 0, 0, "R2");
    cyc(1, 3'b011, 12'h343, 32'h0000_0030, 0, 0, 0, 0, 0, 0, 0, "R2");
    expect_val(12'h343, 32'h0000_00C0, "R2");
    cyc(1, 3'b000, 12'h343, 32'h1, 0, 0, 0, 0, 0, 0, 0, "R2");
    // R3 immediate zero-extended, register operand ignored
    cyc(1, 3'b101, 12'h340, 32'hFFFF_FFFF, 5'h1F, 0, 0, 0, 0, 0, 0, "R3");
    expect_val(12'h340, 32'h0000_001F, "R3");
    // R4 zero operand on read-only and on writable
    cyc(1, 3'b111, 12'hF14, 32'hFFFF, 5'd0, 0, 0, 0, 0, 0, 0, "R4");
    cyc(1, 3'b011, 12'h340, 32'h0, 0, 0, 0, 0, 0, 0, 0, "R4");
    expect_val(12'h340, 32'h0000_001F, "R4");
    // R5 rd_zero write
    cyc(1, 3'b001, 12'h340, 32'h1234_5678, 0, 1, 0, 0, 0, 0, 0, "R5");
    chk(1'b1, "R5", 0, 0);
    expect_val(12'h340, 32'h1234_5678, "R5");
    // R7 vector and exception PC alignment
    cyc(1, 3'b001, 12'h305, 32'h0000_2003, 0, 0, 0, 0, 0, 0, 0, "R7");
    cyc(1, 3'b001, 12'h341, 32'h0000_0055, 0, 0, 0, 0, 0, 0, 0, "R7");
    expect_val(12'h341, 32'h0000_0054, "R7");
    // R8 status write mask
    cyc(1, 3'b001, 12'h300, 32'hFFFF_FFFF, 0, 0, 0, 0, 0, 0, 0, "R8");
    expect_val(12'h300, 32'h0000_1888, "R8");
    // R6 environment call trap
    cyc(0, 3'b000, 0, 0, 0, 0, 1, 32'd8, 32'h0000_1003, 32'hABCD, 0, "R6");
    expect_val(12'h342, 32'd8, "R6");
    expect_val(12'h341, 32'h0000_1002, "R6");
    expect_val(12'h343, 32'h0000_ABCD, "R6");
    expect_val(12'h300, 32'h0000_1880, "R8");
    // R8 return
    cyc(0, 3'b000, 0, 0, 0, 0, 0, 0, 0, 0, 1, "R8");
    expect_val(12'h300, 32'h0000_1888, "R8");
    // R9 unimplemented address
    cyc(1, 3'b001, 12'h7C0, 32'h1, 0, 0, 0, 0, 0, 0, 0, "R9");
    // R10 trap beats write and return
    cyc(1, 3'b001, 12'h340, 32'h0BAD_0BAD, 0, 0, 1, 32'd2, 32'h400, 0, 1, "R10");
    expect_val(12'h340, 32'h1234_5678, "R10");
    expect_val(12'h300, 32'h0000_1880, "R10");
    cyc(1, 3'b001, 12'h340, 32'h0BAD_0BAD, 0, 0, 0, 0, 0, 0, 1, "R10");
    expect_val(12'h340, 32'h1234_5678, "R10");

    // constrained random mix
    for (int i = 0; i < 4000; i++) begin
      logic [11:0] addrs [9];
      logic [31:0] s;
      addrs = '{12'h300, 12'h305, 12'h340, 12'h341, 12'h342, 12'h343, 12'hF14, 12'h7C0, 12'hC00};
      s = ($urandom % 4 == 0) ? 32'h0 : $urandom;
      cyc(($urandom % 4) != 0, 3'($urandom), addrs[$urandom % 9], s, 5'($urandom),
          ($urandom % 8) == 0, ($urandom % 20) == 0, $urandom, $urandom, $urandom,
          ($urandom % 20) == 0, "R1/R2/R3/R10 random");
    end
    rd(12'h300, "R8");

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial void'($urandom(32'h5EED_C5A7));
endmodule